// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Cycle Controller

This block sits between a clocked internal request port and an external asynchronous static RAM. The RAM is 8 bits wide with 19 address bits. A request is a single read or write. The controller turns it into a sequence of chip-enable, output-enable and write-enable levels on the memory pins. Every phase lasts a whole number of system clocks, and each phase length is derived from a memory timing figure given in nanoseconds.

The data bus towards the memory is split into three parts: an output value, an input value and a drive enable. The pad ring builds the bidirectional pin from these. The controller never enables its drivers while the memory could still be driving the bus. After every access it keeps the chip deselected long enough for the memory to release the bus and to recover. Only then does it accept the next request. A read returns its byte together with a one-cycle done pulse. A write also signals completion with a one-cycle done pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and just after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: Each phase length in cycles is the ceiling of the nanosecond parameter divided by CLK_NS. This covers read cycle, access, output-enable-to-valid, output-enable release, chip-enable release, write pulse and recovery.
- R3: A read is accepted on the edge where req_valid and req_ready are both 1. Starting in the next cycle, for RD = max(read cycle, access, OE-valid) cycles, mem_addr equals the request address, mem_ce_n and mem_oe_n are 0 and mem_we_n is 1.
- R4: Read data is sampled from mem_dq_in on the edge that ends cycle CAP = max(access, OE-valid) of the read. rsp_rdata then holds that byte, and rsp_done is 1 in the following cycle only.
- R5: A write keeps mem_we_n at 0 and mem_dq_oe at 1 together for exactly the write-pulse count, starting in the cycle after acceptance. During that time mem_ce_n is 0 and mem_dq_out carries the request data.
- R6: After the write pulse there is exactly one cycle in which mem_ce_n is 0, mem_we_n is 1 and mem_dq_oe is 0. In that cycle mem_addr and mem_dq_out are unchanged.
- R7: mem_dq_oe is never 1 while the memory may be driving the bus (mem_ce_n=0, mem_oe_n=0, mem_we_n=1). It also stays 0 within max(OE release, CE release) cycles after the memory stops driving.
- R8: After each access, mem_ce_n stays 1 for a gap. The gap is max(recovery, release) cycles after a read and recovery cycles after a write. req_ready returns to 1 in the cycle after the gap.
- R9: req_ready is 1 only while the controller is idle. A request held valid while req_ready is 0 is ignored and leaves memory contents and pin sequence unchanged.
- R10: A write raises rsp_done for one cycle, in the first cycle in which mem_ce_n is back at 1.
- R11: mem_oe_n stays 1 throughout a write; mem_oe_n and mem_we_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte returned by the last read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven towards the memory |
| mem_dq_in | input | DATA_W | Data seen on the memory bus |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |

## Verification
The bench is driven with isolated writes and reads to the lowest, highest and a mid-range address. It also runs back-to-back reads of different addresses, a write directly followed by a read of the same byte, and a read directly followed by a write. The back-to-back runs separate correct gap lengths from shortened ones. The read-then-write pair exposes any early drive of the bus inside the release window. The memory model returns a garbage byte until both the access count and the OE-valid count have run out, so capturing one edge early gives wrong data. A burst of requests held valid while the controller is busy must leave the pin sequence and the stored byte untouched.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_WHOLD = 3'd3,
      ST_GAP   = 3'd4
   } ctl_state_e;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] ONE = CW'(1);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   // counts cycles spent in the current phase; 1 in its first cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= ONE;
      else if (cnt != TOP)
         cnt <= cnt + ONE;
   end

endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int CW     = 6,
   parameter int N_CAP  = 14,
   parameter int N_RD   = 14,
   parameter int N_WP   = 10,
   parameter int N_GAPR = 14,
   parameter int N_GAPW = 14,
   parameter int N_REL  = 8,
   parameter int N_REC  = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [CW-1:0] cnt,
   output logic          cnt_clr,
   output logic          accept,
   output logic          capture,
   output logic          ready,
   output logic          done,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n,
   output logic          dq_oe
);

   localparam logic [CW-1:0] K_CAP  = CW'(N_CAP);
   localparam logic [CW-1:0] K_RD   = CW'(N_RD);
   localparam logic [CW-1:0] K_WP   = CW'(N_WP);
   localparam logic [CW-1:0] K_GAPR = CW'(N_GAPR);
   localparam logic [CW-1:0] K_GAPW = CW'(N_GAPW);
   localparam logic [CW-1:0] K_REL  = CW'(N_REL);
   localparam logic [CW-1:0] K_REC  = CW'(N_REC);
   localparam logic [CW-1:0] K_TOP  = {CW{1'b1}};

   ctl_state_e st_q;
   logic       after_rd_q;
   logic [CW-1:0] gap_lim;

   assign ready   = (st_q == ST_IDLE);
   assign accept  = ready && req_valid;
   assign capture = (st_q == ST_READ) && (cnt == K_CAP);
   assign gap_lim = after_rd_q ? K_GAPR : K_GAPW;

   always_comb begin
      cnt_clr = 1'b0;
      unique case (st_q)
         ST_IDLE:  cnt_clr = req_valid;
         ST_READ:  cnt_clr = (cnt >= K_RD);
         ST_WRITE: cnt_clr = (cnt >= K_WP);
         ST_WHOLD: cnt_clr = 1'b1;
         default:  cnt_clr = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         after_rd_q <= 1'b0;
         ce_n       <= 1'b1;
         oe_n       <= 1'b1;
         we_n       <= 1'b1;
         dq_oe      <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  ce_n       <= 1'b0;
                  after_rd_q <= !req_write;
                  if (req_write) begin
                     we_n  <= 1'b0;
                     dq_oe <= 1'b1;
                     st_q  <= ST_WRITE;
                  end else begin
                     oe_n  <= 1'b0;
                     st_q  <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (cnt == K_CAP)
                  done <= 1'b1;
               if (cnt >= K_RD) begin
                  ce_n <= 1'b1;
                  oe_n <= 1'b1;
                  st_q <= ST_GAP;
               end
            end
            ST_WRITE: begin
               if (cnt >= K_WP) begin
                  we_n  <= 1'b1;
                  dq_oe <= 1'b0;
                  st_q  <= ST_WHOLD;
               end
            end
            ST_WHOLD: begin
               ce_n <= 1'b1;
               done <= 1'b1;
               st_q <= ST_GAP;
            end
            ST_GAP: begin
               if (cnt >= gap_lim)
                  st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // watch counters for the checks below
   logic [CW-1:0] quiet_q;   // cycles since the memory last drove the bus
   logic [CW-1:0] desel_q;   // cycles chip enable has been high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= K_TOP;
         desel_q <= K_TOP;
      end else begin
         if (!ce_n && !oe_n && we_n) quiet_q <= '0;
         else if (quiet_q != K_TOP)  quiet_q <= quiet_q + CW'(1);
         if (!ce_n)                  desel_q <= '0;
         else if (desel_q != K_TOP)  desel_q <= desel_q + CW'(1);
      end
   end

   AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!we_n && !ce_n)); // R5
   AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || we_n)); // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ce_n && oe_n && we_n && !dq_oe)); // R9
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (quiet_q >= K_REL)); // R7
   AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |-> ($past(desel_q) >= K_REC)); // R8
   AST_HOLD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !ce_n); // R6

endmodule

// File: rtl/sram_ctl_dp.sv
`timescale 1ns/1ps
module sram_ctl_dp #(
   parameter int AW = 19,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] mem_dq_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_out,
   output logic [DW-1:0] rsp_rdata
);

   // address and write byte stay put from acceptance until the next one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (load) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   // one capture flop per data bit, loaded on the sampling edge
   for (genvar b = 0; b < DW; b++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rsp_rdata[b] <= 1'b0;
         else if (capture)
            rsp_rdata[b] <= mem_dq_in[b];
      end
   end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 4,
   parameter int T_RC_NS   = 55,
   parameter int T_AA_NS   = 55,
   parameter int T_OE_NS   = 30,
   parameter int T_OHZ_NS  = 25,
   parameter int T_CHZ_NS  = 30,
   parameter int T_WP_NS   = 40,
   parameter int T_REC_NS  = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int C_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);
   localparam int C_AA  = ns_to_cyc(T_AA_NS,  CLK_NS);
   localparam int C_OE  = ns_to_cyc(T_OE_NS,  CLK_NS);
   localparam int C_OHZ = ns_to_cyc(T_OHZ_NS, CLK_NS);
   localparam int C_CHZ = ns_to_cyc(T_CHZ_NS, CLK_NS);
   localparam int C_WP  = ns_to_cyc(T_WP_NS,  CLK_NS);
   localparam int C_REC = ns_to_cyc(T_REC_NS, CLK_NS);

   localparam int C_CAP  = imax(C_AA, C_OE);
   localparam int C_RD   = imax(C_CAP, C_RC);
   localparam int C_REL  = imax(C_OHZ, C_CHZ);
   localparam int C_GAPR = imax(C_REC, C_REL);
   localparam int C_GAPW = C_REC;
   localparam int C_MAX  = imax(imax(C_RD, C_WP), C_GAPR);
   localparam int CW     = $clog2(C_MAX + 1) + 1;

   // elaboration-time parameter checks
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_ctl: CLK_NS must be at least 1");
   end
   if (T_RC_NS < 1 || T_AA_NS < 1 || T_OE_NS < 1 || T_OHZ_NS < 1 ||
       T_CHZ_NS < 1 || T_WP_NS < 1 || T_REC_NS < 1) begin : g_bad_time
      $error("sram_ctl: every timing figure must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_ctl: bus widths must be positive");
   end

   logic [CW-1:0] phase_cnt;
   logic          cnt_clr;
   logic          accept;
   logic          capture;

   sram_ctl_timer #(.CW(CW)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .cnt   (phase_cnt)
   );

   sram_ctl_seq #(
      .CW     (CW),
      .N_CAP  (C_CAP),
      .N_RD   (C_RD),
      .N_WP   (C_WP),
      .N_GAPR (C_GAPR),
      .N_GAPW (C_GAPW),
      .N_REL  (C_REL),
      .N_REC  (C_REC)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .cnt       (phase_cnt),
      .cnt_clr   (cnt_clr),
      .accept    (accept),
      .capture   (capture),
      .ready     (req_ready),
      .done      (rsp_done),
      .ce_n      (mem_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_ctl_dp #(.AW(ADDR_W), .DW(DATA_W)) i_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_rdata  (rsp_rdata)
   );

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6
   AST_ADDR_STABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R3

endmodule

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

   localparam int AW     = 19;
   localparam int DW     = 8;
   localparam int CLKP   = 4;
   localparam int RC_NS  = 70;
   localparam int REC_NS = 20;

   function automatic int up(input int ns);
      return (ns + CLKP - 1) / CLKP;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R2: expected phase lengths, rounded up from nanoseconds
   localparam int E_RC  = up(RC_NS);
   localparam int E_AA  = up(55);
   localparam int E_OE  = up(30);
   localparam int E_REL = mx(up(25), up(30));
   localparam int E_WP  = up(40);
   localparam int E_REC = up(REC_NS);
   localparam int E_CAP = mx(E_AA, E_OE);
   localparam int E_RD  = mx(E_CAP, E_RC);
   localparam int E_GR  = mx(E_REC, E_REL);
   localparam int E_GW  = E_REC;

   logic          clk;
   logic          rst_n;
   logic          req_valid;
   logic          req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_ready;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n;
   logic          mem_oe_n;
   logic          mem_we_n;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;
   logic          mem_dq_oe;

   sram_ctl #(.T_RC_NS(RC_NS), .T_REC_NS(REC_NS)) i_sram_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .rsp_done   (rsp_done),
      .rsp_rdata  (rsp_rdata),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_in  (mem_dq_in),
      .mem_dq_oe  (mem_dq_oe)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0]    ram [int];
   logic [7:0]    ref_ram [int];
   int            a_cnt = 0, o_cnt = 0, rel = 1000, wcnt = 0;
   logic [AW-1:0] prev_addr = '0;
   bit            we_low_prev = 0;
   logic [7:0]    wlast = '0;

   // ---------------- reference model ----------------
   bit            busy = 0;
   bit            op_wr = 0;
   int            t = 0;
   logic [AW-1:0] op_a = '0;
   logic [7:0]    op_d = '0;
   logic [7:0]    op_exp = '0;

   initial mem_dq_in = 8'hEE;

   always @(negedge clk) begin
      if (rst_n) begin
         bit drv;
         int total;
         bit e_ce, e_oe, e_we, e_oen, e_rdy, e_done;
         string rq;

         // memory side: write capture, drive window, contention
         if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            wcnt++;
            wlast = mem_dq_out;
         end
         if (we_low_prev && mem_we_n) begin
            chk(wcnt == E_WP, "R2", "write pulse cycles", wcnt, E_WP);
            ram[int'(mem_addr)] = wlast;
            wcnt = 0;
         end
         we_low_prev = !mem_we_n;
         drv = !mem_ce_n && !mem_oe_n && mem_we_n;
         chk(!(mem_dq_oe && (drv || rel < E_REL)), "R7", "drive during release", rel, E_REL);
         if (drv) begin
            if (mem_addr != prev_addr) a_cnt = 0;
            a_cnt++;
            o_cnt++;
            rel = 0;
         end else begin
            a_cnt = 0;
            o_cnt = 0;
            if (rel < 1000) rel++;
         end
         prev_addr = mem_addr;
         if (drv && a_cnt >= E_AA && o_cnt >= E_OE)
            mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
         else
            mem_dq_in = 8'hEE;

         // expected pins for this cycle
         if (busy) t++;
         e_ce = 1; e_oe = 1; e_we = 1; e_oen = 0; e_rdy = !busy; e_done = 0;
         total = 0;
         rq = "R9";
         if (busy && !op_wr) begin
            total = E_RD + E_GR;
            if (t <= E_RD) begin e_ce = 0; e_oe = 0; rq = "R3"; end
            else rq = "R8";
            e_done = (t == E_CAP + 1);
         end else if (busy && op_wr) begin
            total = E_WP + 1 + E_GW;
            if (t <= E_WP) begin e_ce = 0; e_we = 0; e_oen = 1; rq = "R5"; end
            else if (t == E_WP + 1) begin e_ce = 0; rq = "R6"; end
            else rq = "R8";
            e_done = (t == E_WP + 2);
         end
         chk(mem_ce_n == e_ce, rq, "mem_ce_n", mem_ce_n, e_ce);
         chk(mem_oe_n == e_oe, (busy && op_wr) ? "R11" : rq, "mem_oe_n", mem_oe_n, e_oe);
         chk(mem_we_n == e_we, rq, "mem_we_n", mem_we_n, e_we);
         chk(mem_dq_oe == e_oen, rq, "mem_dq_oe", mem_dq_oe, e_oen);
         chk(req_ready == e_rdy, "R9", "req_ready", req_ready, e_rdy);
         chk(rsp_done == e_done, op_wr ? "R10" : "R4", "rsp_done", rsp_done, e_done);
         if (busy && !e_ce)
            chk(mem_addr == op_a, rq, "mem_addr", int'(mem_addr), int'(op_a));
         if (busy && op_wr && t <= E_WP + 1)
            chk(mem_dq_out == op_d, (t <= E_WP) ? "R5" : "R6", "mem_dq_out", mem_dq_out, op_d);
         if (e_done && !op_wr)
            chk(rsp_rdata == op_exp, "R4", "rsp_rdata", rsp_rdata, op_exp);

         if (busy) begin
            if (t == total) busy = 0;
         end else if (req_valid) begin
            busy  = 1;
            t     = 0;
            op_wr = req_write;
            op_a  = req_addr;
            op_d  = req_wdata;
            if (req_write) ref_ram[int'(req_addr)] = req_wdata;
            else op_exp = ref_ram.exists(int'(req_addr)) ? ref_ram[int'(req_addr)] : 8'h00;
         end
      end
   end

   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [7:0] d);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      do @(negedge clk); while (!req_ready);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!req_ready);
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      repeat (3) begin
         @(negedge clk);
         // R1 reset values
         chk(mem_ce_n == 1 && mem_oe_n == 1 && mem_we_n == 1, "R1", "strobes in reset",
             {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
         chk(mem_dq_oe == 0, "R1", "mem_dq_oe in reset", mem_dq_oe, 0);
         chk(req_ready == 1 && rsp_done == 0, "R1", "ready/done in reset",
             {req_ready, rsp_done}, 2'b10);
      end
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;

      // isolated writes at the address extremes and mid range
      issue(1'b1, 19'h00000, 8'h5A);
      wait_idle();
      issue(1'b1, 19'h7FFFF, 8'hA5);
      wait_idle();
      issue(1'b1, 19'h12345, 8'h3C);
      wait_idle();

      // back-to-back reads of different addresses
      issue(1'b0, 19'h00000, 8'h00);
      issue(1'b0, 19'h7FFFF, 8'h00);
      issue(1'b0, 19'h12345, 8'h00);

      // write directly followed by read of the same byte
      issue(1'b1, 19'h00100, 8'hC3);
      issue(1'b0, 19'h00100, 8'h00);

      // read directly followed by write (bus turnaround), then read back
      issue(1'b0, 19'h12345, 8'h00);
      issue(1'b1, 19'h12345, 8'h81);
      issue(1'b0, 19'h12345, 8'h00);
      wait_idle();

      // R9: requests held while busy are ignored
      issue(1'b0, 19'h00100, 8'h00);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = 19'h00100;
      req_wdata = 8'h00;
      repeat (6) @(posedge clk);
      #1;
      req_valid = 1'b0;
      wait_idle();
      issue(1'b0, 19'h00100, 8'h00);
      wait_idle();
      chk(rsp_rdata == 8'hC3, "R9", "byte after ignored write", rsp_rdata, 8'hC3);

      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule